// File: doc/BRIEF.md
# Dual-Issue Pairing Sequencer

This block sits between an instruction queue and a two-pipe in-order integer core whose pipes are named U and V. Decoded instructions arrive one per cycle on a valid/ready input stream and are held in an internal queue. Each cycle the two oldest queued entries form a candidate issue group. A pairing checker decides whether both can issue together, with the older entry in U and the younger in V, or whether the older issues alone.

The decision depends on two things. The first is a per-class table that says which pipe each operation class may occupy. Some classes may use either pipe, carry arithmetic is limited to U, branches are limited to V, and complex operations never pair. The second is a register check against the older entry's destination. The issue side is a valid/ready stream. An issue group leaves only on a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low the older entry stays at the head. The input side accepts a new entry whenever the queue holds fewer than `DEPTH` entries. Pops in the same cycle give no credit, so `in_ready` does not depend on `iss_ready` in the same cycle. Two counters record how many issue cycles were paired and how many were single.

Descriptor fields at the input are: `in_cls` (operation class), `in_wr_vld`/`in_wr` (destination register), and `in_rd_vld[k]` with `in_rd0`/`in_rd1` (source registers). Bit 0 of `in_rd_vld` qualifies `in_rd0` and bit 1 qualifies `in_rd1`.

Top module: `pair_issue_unit`

## Requirements
- R1: When a group pairs, the older entry (tag on `iss_tag_old`) goes to U and the younger (tag on `iss_tag_young`) goes to V, and both leave the queue in one handshake. When a group does not pair, only the older entry leaves.
- R2: Classes 0 (register/immediate move), 1 (push), 2 (pop) and 3 (increment, decrement, add, subtract, compare, and, or, xor) are eligible in both U and V.
- R3: Class 4 (add-with-carry, subtract-with-borrow) is eligible only in U. It can pair as the older entry but never as the younger.
- R4: Class 5 (near call, short or near jump, conditional or not) is eligible only in V. As the younger entry it can pair. As the older entry it issues alone with `iss_steer_v`=1. In every other case `iss_steer_v`=0.
- R5: Classes 6 and 7 (complex operations) are eligible in neither pipe and always issue alone in U.
- R6: The pair is rejected if the older entry has a valid destination and the younger entry writes that register, or reads it through a source whose valid bit is set.
- R7: After a rejected pair, the younger entry is the older entry of the next issue group.
- R8: `iss_reason` is 0 for paired, 1 when the older entry is not U-eligible, 2 when the younger entry is not V-eligible, and 3 for a register conflict. When several apply, the lowest nonzero code wins. `iss_pair` is high exactly when the reason is 0.
- R9: A queue holding only one entry issues it alone with reason 2.
- R10: While `iss_valid` is high and `iss_ready` is low, no entry leaves, the head entry is unchanged and the counters hold.
- R11: `in_ready` is low exactly when the queue holds `DEPTH` entries. No entry is accepted then.
- R12: On every issue handshake exactly one of `paired_cnt` and `single_cnt` increments (CNT_W bits, wrapping), according to `iss_pair`.
- R13: A synchronous reset (`rst` high at a clock edge) empties the queue and clears both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input entry valid |
| in_ready | output | 1 | Queue can accept an entry |
| in_cls | input | 3 | Operation class code |
| in_wr_vld | input | 1 | Destination register present |
| in_wr | input | REG_W | Destination register |
| in_rd_vld | input | 2 | Source valid bits (bit 0: in_rd0, bit 1: in_rd1) |
| in_rd0 | input | REG_W | First source register |
| in_rd1 | input | REG_W | Second source register |
| in_tag | input | TAG_W | Entry identifier carried to the issue side |
| iss_valid | output | 1 | An issue group is offered |
| iss_ready | input | 1 | Core accepts the issue group |
| iss_pair | output | 1 | Both entries issue this group |
| iss_steer_v | output | 1 | Older entry goes to V instead of U |
| iss_reason | output | 2 | Pairing outcome code |
| iss_tag_old | output | TAG_W | Tag of the older entry |
| iss_tag_young | output | TAG_W | Tag of the younger entry (meaningful when paired) |
| paired_cnt | output | CNT_W | Count of paired issue cycles |
| single_cnt | output | CNT_W | Count of single issue cycles |

## Verification
Some properties are checked on every cycle: the stall hold on the head entry, that a paired group never steers to V, that the counters move exactly as the handshake and `iss_pair` dictate, that `in_ready` stays high while the queue is empty, and the cleared state after reset. Other behaviour can only be shown by the bench's scenarios against its queue model. This covers the class eligibility table, the conflict rules for each source slot, the priority between reason codes, and the promotion of a rejected younger entry. It also covers the full-queue boundary, which the bench reaches by filling the queue under stall and then comparing every decision and tag in each cycle.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int REG_W = 3;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_MOVE    = 3'd0,
    CLS_PUSH    = 3'd1,
    CLS_POP     = 3'd2,
    CLS_ARITH   = 3'd3,
    CLS_CARRY   = 3'd4,
    CLS_BRANCH  = 3'd5,
    CLS_COMPLEX = 3'd6,
    CLS_RSVD    = 3'd7
  } op_class_e;

  typedef enum logic [1:0] {
    RSN_PAIR   = 2'd0,
    RSN_FIRST  = 2'd1,
    RSN_SECOND = 2'd2,
    RSN_DEP    = 2'd3
  } reason_e;

  typedef struct packed {
    op_class_e        cls;
    logic             wr_v;
    logic [REG_W-1:0] wr;
    logic [1:0]       rd_v;
    logic [REG_W-1:0] rd0;
    logic [REG_W-1:0] rd1;
  } slot_desc_t;
endpackage

// File: rtl/pair_elig.sv
module pair_elig
  import pair_pkg::*;
(
  input  op_class_e cls,
  output logic      u_ok,
  output logic      v_ok
);
  always_comb begin
    u_ok = 1'b0;
    v_ok = 1'b0;
    unique case (cls)
      CLS_MOVE, CLS_PUSH, CLS_POP, CLS_ARITH: begin
        u_ok = 1'b1;
        v_ok = 1'b1;
      end
      CLS_CARRY:  u_ok = 1'b1;
      CLS_BRANCH: v_ok = 1'b1;
      default: begin
        u_ok = 1'b0;
        v_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  slot_desc_t older,
  input  slot_desc_t younger,
  output logic       conflict
);
  logic [NSRC-1:0] rd_hit;
  logic            wr_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    if (k == 0) begin : g_first
      assign rd_hit[k] = younger.rd_v[k] && (younger.rd0 == older.wr);
    end else begin : g_second
      assign rd_hit[k] = younger.rd_v[k] && (younger.rd1 == older.wr);
    end
  end

  assign wr_hit   = younger.wr_v && (younger.wr == older.wr);
  assign conflict = older.wr_v && (wr_hit || (|rd_hit));
endmodule

// File: rtl/pair_decide.sv
module pair_decide
  import pair_pkg::*;
(
  input  slot_desc_t slot0,
  input  slot_desc_t slot1,
  input  logic       slot1_vld,
  output logic       pair,
  output logic       steer_v,
  output reason_e    reason
);
  logic u0_ok, v0_ok, u1_ok, v1_ok, hz;

  pair_elig u_elig0 (.cls(slot0.cls), .u_ok(u0_ok), .v_ok(v0_ok));
  pair_elig u_elig1 (.cls(slot1.cls), .u_ok(u1_ok), .v_ok(v1_ok));

  pair_hazard #(.NSRC(2)) u_hz (
    .older   (slot0),
    .younger (slot1),
    .conflict(hz)
  );

  always_comb begin
    if (!u0_ok)                      reason = RSN_FIRST;
    else if (!slot1_vld || !v1_ok)   reason = RSN_SECOND;
    else if (hz)                     reason = RSN_DEP;
    else                             reason = RSN_PAIR;
  end

  assign pair    = (reason == RSN_PAIR);
  // a lone V-only entry travels down the V pipe, all other lone entries take U
  assign steer_v = !pair && v0_ok && !u0_ok;

  logic unused_ok;
  assign unused_ok = u1_ok;
endmodule

// File: rtl/issue_fifo.sv
module issue_fifo
  import pair_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  slot_desc_t       push_desc,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [1:0]       pop_n,
  output logic [CNT_W-1:0] cnt,
  output slot_desc_t       h0_desc,
  output logic [TAG_W-1:0] h0_tag,
  output slot_desc_t       h1_desc,
  output logic [TAG_W-1:0] h1_tag
);
  slot_desc_t       desc_mem [DEPTH];
  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_nxt  = adv(rd_ptr);
  assign h0_desc = desc_mem[rd_ptr];
  assign h0_tag  = tag_mem[rd_ptr];
  assign h1_desc = desc_mem[rd_nxt];
  assign h1_tag  = tag_mem[rd_nxt];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        desc_mem[i] <= '0;
        tag_mem[i]  <= '0;
      end
    end else begin
      if (push) begin
        desc_mem[wr_ptr] <= push_desc;
        tag_mem[wr_ptr]  <= push_tag;
        wr_ptr           <= adv(wr_ptr);
      end
      case (pop_n)
        2'd1:    rd_ptr <= rd_nxt;
        2'd2:    rd_ptr <= adv(rd_nxt);
        default: rd_ptr <= rd_ptr;
      endcase
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop_n);
    end
  end
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import pair_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  localparam int QC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_cls,
  input  logic             in_wr_vld,
  input  logic [REG_W-1:0] in_wr,
  input  logic [1:0]       in_rd_vld,
  input  logic [REG_W-1:0] in_rd0,
  input  logic [REG_W-1:0] in_rd1,
  input  logic [TAG_W-1:0] in_tag,
  output logic             iss_valid,
  input  logic             iss_ready,
  output logic             iss_pair,
  output logic             iss_steer_v,
  output logic [1:0]       iss_reason,
  output logic [TAG_W-1:0] iss_tag_old,
  output logic [TAG_W-1:0] iss_tag_young,
  output logic [CNT_W-1:0] paired_cnt,
  output logic [CNT_W-1:0] single_cnt
);
  slot_desc_t      in_desc, h0, h1;
  logic [QC_W-1:0] qcnt;
  logic            push, fire;
  logic [1:0]      pop_n;
  reason_e         rsn;

  assign in_desc = '{cls: op_class_e'(in_cls), wr_v: in_wr_vld, wr: in_wr,
                     rd_v: in_rd_vld, rd0: in_rd0, rd1: in_rd1};

  assign in_ready  = (qcnt != QC_W'(DEPTH));
  assign push      = in_valid && in_ready;
  assign iss_valid = (qcnt != '0);
  assign fire      = iss_valid && iss_ready;
  assign pop_n     = fire ? (iss_pair ? 2'd2 : 2'd1) : 2'd0;

  issue_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_q (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_desc(in_desc),
    .push_tag (in_tag),
    .pop_n    (pop_n),
    .cnt      (qcnt),
    .h0_desc  (h0),
    .h0_tag   (iss_tag_old),
    .h1_desc  (h1),
    .h1_tag   (iss_tag_young)
  );

  pair_decide u_dec (
    .slot0    (h0),
    .slot1    (h1),
    .slot1_vld(qcnt >= QC_W'(2)),
    .pair     (iss_pair),
    .steer_v  (iss_steer_v),
    .reason   (rsn)
  );
  assign iss_reason = rsn;

  always_ff @(posedge clk) begin
    if (rst) begin
      paired_cnt <= '0;
      single_cnt <= '0;
    end else if (fire) begin
      if (iss_pair) paired_cnt <= paired_cnt + 1'b1;
      else          single_cnt <= single_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pair_issue_sva.sv
module pair_issue_sva #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             iss_pair,
  input logic             iss_steer_v,
  input logic [TAG_W-1:0] iss_tag_old,
  input logic [CNT_W-1:0] paired_cnt,
  input logic [CNT_W-1:0] single_cnt
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_tag_old));

  assert_pair_in_u_R4: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_pair |-> !iss_steer_v);

  assert_paired_inc_R12: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_ready && iss_pair |=>
      paired_cnt == $past(paired_cnt) + 1'b1 && $stable(single_cnt));

  assert_single_inc_R12: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_ready && !iss_pair |=>
      single_cnt == $past(single_cnt) + 1'b1 && $stable(paired_cnt));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && iss_ready) |=> $stable(paired_cnt) && $stable(single_cnt));

  assert_empty_accepts_R11: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |-> in_ready);

  assert_reset_clear_R13: assert property (@(posedge clk)
    rst |=> paired_cnt == '0 && single_cnt == '0 && !iss_valid);
endmodule

bind pair_issue_unit pair_issue_sva #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_pair   (iss_pair),
  .iss_steer_v(iss_steer_v),
  .iss_tag_old(iss_tag_old),
  .paired_cnt (paired_cnt),
  .single_cnt (single_cnt)
);

// File: tb/sim_pair_issue_unit.sv
module sim_pair_issue_unit;
  localparam int DEPTH = 8;
  localparam int TAG_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, iss_ready = 1'b0;
  logic in_ready;
  logic [2:0] in_cls = '0;
  logic in_wr_vld = 1'b0;
  logic [2:0] in_wr = '0, in_rd0 = '0, in_rd1 = '0;
  logic [1:0] in_rd_vld = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic iss_valid, iss_pair, iss_steer_v;
  logic [1:0] iss_reason;
  logic [TAG_W-1:0] iss_tag_old, iss_tag_young;
  logic [CNT_W-1:0] paired_cnt, single_cnt;

  always #5 clk = ~clk;

  pair_issue_unit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u0 (.*);

  typedef struct {
    int cls; bit wv; int wr; bit [1:0] rv; int r0; int r1; bit [7:0] tag;
  } ins_t;

  ins_t q[$];
  ins_t pend[$];
  int checks = 0, errors = 0;
  int exp_paired = 0, exp_single = 0;
  bit done = 0;

  function automatic ins_t mk(int c, bit wv, int wr, bit [1:0] rv, int r0, int r1, int t);
    ins_t x;
    x.cls = c; x.wv = wv; x.wr = wr; x.rv = rv; x.r0 = r0; x.r1 = r1; x.tag = t[7:0];
    return x;
  endfunction

  function automatic int exp_reason();
    int c0, c1;
    if (q.size() == 0) return 0;
    c0 = q[0].cls;
    if (c0 > 4) return 1;
    if (q.size() < 2) return 2;
    c1 = q[1].cls;
    if (!(c1 <= 3 || c1 == 5)) return 2;
    if (q[0].wv && ((q[1].wv && q[1].wr == q[0].wr) ||
                    (q[1].rv[0] && q[1].r0 == q[0].wr) ||
                    (q[1].rv[1] && q[1].r1 == q[0].wr))) return 3;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    int r;
    chk(iss_valid === (q.size() > 0), "R1 iss_valid", iss_valid, q.size() > 0);
    chk(in_ready === (q.size() < DEPTH), "R11 in_ready", in_ready, q.size() < DEPTH);
    chk(paired_cnt === CNT_W'(exp_paired), "R12 paired_cnt", paired_cnt, exp_paired);
    chk(single_cnt === CNT_W'(exp_single), "R12 single_cnt", single_cnt, exp_single);
    if (q.size() > 0) begin
      r = exp_reason();
      chk(iss_reason === 2'(r), "R8 reason", iss_reason, r);
      chk(iss_pair === (r == 0), "R8 pair", iss_pair, r == 0);
      chk(iss_steer_v === (r != 0 && q[0].cls == 5), "R4 steer", iss_steer_v,
          r != 0 && q[0].cls == 5);
      chk(iss_tag_old === q[0].tag, "R1 older tag", iss_tag_old, q[0].tag);
      if (r == 0)
        chk(iss_tag_young === q[1].tag, "R1 younger tag", iss_tag_young, q[1].tag);
    end
  endtask

  task automatic step(bit rdy);
    bit pu;
    int pn;
    compare();
    if (pend.size() > 0) begin
      in_valid = 1'b1; in_cls = 3'(pend[0].cls); in_wr_vld = pend[0].wv;
      in_wr = 3'(pend[0].wr); in_rd_vld = pend[0].rv; in_rd0 = 3'(pend[0].r0);
      in_rd1 = 3'(pend[0].r1); in_tag = pend[0].tag;
    end else begin
      in_valid = 1'b0;
    end
    iss_ready = rdy;
    pu = in_valid && (q.size() < DEPTH);
    pn = 0;
    if (rdy && q.size() > 0) pn = (exp_reason() == 0) ? 2 : 1;
    @(posedge clk);
    if (pn == 2) exp_paired++;
    if (pn == 1) exp_single++;
    repeat (pn) void'(q.pop_front());
    if (pu) q.push_back(pend.pop_front());
    @(negedge clk);
  endtask

  task automatic fill();
    while (pend.size() > 0 && q.size() < DEPTH) step(1'b0);
  endtask

  task automatic drain();
    while (q.size() > 0 || pend.size() > 0) step(1'b1);
  endtask

  task automatic expect_head(int r, bit s, int t, string req);
    checks++;
    if (iss_valid !== 1'b1 || iss_reason !== 2'(r) || iss_steer_v !== s ||
        iss_tag_old !== 8'(t)) begin
      errors++;
      $display("FAIL %s: valid=%0b reason=%0d steer=%0b tag=%0d expected reason=%0d steer=%0b tag=%0d",
               req, iss_valid, iss_reason, iss_steer_v, iss_tag_old, r, s, t);
    end
  endtask

  task automatic pair2(ins_t a, ins_t b, int r, bit s, string req);
    pend.push_back(a); pend.push_back(b);
    fill();
    expect_head(r, s, a.tag, req);
    drain();
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk(iss_valid === 1'b0 && paired_cnt === '0 && single_cnt === '0 && in_ready === 1'b1,
        "R13 reset state", iss_valid, 0);

    // R2 moves, push, pop, arith pair freely
    pair2(mk(0,1,0,0,0,0,1), mk(0,1,1,0,0,0,2), 0, 0, "R2 move+move");
    pair2(mk(1,1,6,1,2,0,3), mk(3,1,3,2'b11,4,5,4), 0, 0, "R2 push+arith");
    pair2(mk(2,1,2,0,0,0,5), mk(1,1,6,0,0,0,6), 0, 0, "R2 pop+push");

    // R6 read-after-write, then R7 promotion and R9 lone entry
    pend.push_back(mk(0,1,0,0,0,0,10)); pend.push_back(mk(3,1,1,2'b01,0,0,11));
    fill();
    expect_head(3, 0, 10, "R6 read conflict");
    step(1'b1);
    expect_head(2, 0, 11, "R7 R9 promoted younger");
    drain();
    chk(single_cnt === 16'd2, "R12 after rejected pair", single_cnt, 2);

    // R6 write-write conflict, second-source conflict, invalid source ignored
    pair2(mk(0,1,1,0,0,0,12), mk(2,1,1,0,0,0,13), 3, 0, "R6 write conflict");
    pair2(mk(3,1,2,0,0,0,14), mk(3,1,3,2'b10,0,2,15), 3, 0, "R6 second source");
    pair2(mk(3,1,2,0,0,0,16), mk(3,1,3,2'b00,2,2,17), 0, 0, "R6 invalid source");
    pair2(mk(3,0,2,0,0,0,18), mk(3,1,2,0,0,0,19), 0, 0, "R6 no destination");

    // R3 carry class
    pair2(mk(3,1,2,0,0,0,20), mk(4,1,3,0,0,0,21), 2, 0, "R3 carry young");
    pair2(mk(4,1,3,0,0,0,22), mk(2,1,4,0,0,0,23), 0, 0, "R3 carry old");

    // R4 branch class
    pair2(mk(5,0,0,0,0,0,24), mk(0,1,1,0,0,0,25), 1, 1, "R4 branch old");
    pair2(mk(3,1,0,0,0,0,26), mk(5,0,0,0,0,0,27), 0, 0, "R4 branch young");

    // R5 complex classes
    pair2(mk(6,1,0,0,0,0,28), mk(0,1,1,0,0,0,29), 1, 0, "R5 complex old");
    pair2(mk(0,1,1,0,0,0,30), mk(7,1,2,0,0,0,31), 2, 0, "R5 complex young");

    // R8 priority: first-slot beats conflict, second-slot beats conflict
    pair2(mk(6,1,5,0,0,0,32), mk(0,1,5,0,0,0,33), 1, 0, "R8 first over conflict");
    pair2(mk(3,1,5,0,0,0,34), mk(4,1,6,2'b01,5,0,35), 2, 0, "R8 second over conflict");

    // R10 / R11: stall with a full queue
    for (int i = 0; i < DEPTH + 3; i++) pend.push_back(mk(0, 1, i % 8, 0, 0, 0, 40 + i));
    fill();
    repeat (3) step(1'b0);
    chk(in_ready === 1'b0, "R11 full queue", in_ready, 0);
    expect_head(0, 0, 40, "R10 head held under stall");
    chk(paired_cnt === CNT_W'(exp_paired), "R10 counters held", paired_cnt, exp_paired);
    drain();

    // random mix with irregular back-pressure
    for (int i = 0; i < 400; i++)
      pend.push_back(mk($urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom_range(0, 7),
                        2'($urandom_range(0, 3)), $urandom_range(0, 7), $urandom_range(0, 7), i));
    while (pend.size() > 0 || q.size() > 0) step(($urandom % 4) != 0);

    // R13 mid-run reset
    for (int i = 0; i < 3; i++) pend.push_back(mk(0, 1, i, 0, 0, 0, 100 + i));
    fill();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    q.delete(); pend.delete(); exp_paired = 0; exp_single = 0;
    chk(iss_valid === 1'b0 && paired_cnt === '0 && single_cnt === '0,
        "R13 reset clears", paired_cnt + single_cnt, 0);
    step(1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule